// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog timer behind a single 32-bit register. The first write to that register configures it and locks the configuration until reset. The configuration holds a 12-bit reload count, a prescaler select, a run enable and a 2-bit expiry-action code. After the lock, every write to the register restarts the countdown from the locked reload count, whatever data is written. Software therefore cannot change the timeout once the watchdog is armed. Its only duty is to keep writing before the count runs out.

The countdown advances on a tick that runs at half the bus clock. With the prescaler selected, the tick is divided further by a fixed factor. When a tick arrives while the count is already zero, the watchdog expires. It then freezes its count and raises an interrupt, a reset request, or both, as the action code selects. These outputs hold until reset. A read of the register returns the locked fields, the live count and two status flags.

Top module: `wdog_lockcfg`

## Requirements
- R1: After reset, a read returns all zeros, `irq_o` and `rst_req_o` are low, and the count does not move until the first write.
- R2: The first write locks the fields at fixed bit positions: reload count in bits 11:0, prescaler select in bit 12, run enable in bit 13 and action code in bits 15:14. A read then returns these in the same positions, with bit 28 (locked) set.
- R3: Writes after the lock leave bits 15:0 of the read value unchanged, whatever data they carry.
- R4: Any accepted write loads the count (read bits 27:16) with the reload count and restarts the tick phase and the prescaler.
- R5: With the prescaler off and the watchdog enabled, the count drops by one every 2 bus cycles. The first step comes 2 cycles after the write edge.
- R6: With the prescaler on, the count drops by one every 2*PRESCALE_DIV bus cycles.
- R7: A tick that finds the count at zero sets the expired flag (read bit 29). Expiry occurs exactly 2*D*(reload+1) cycles after the last write edge, where D is 1 or PRESCALE_DIV.
- R8: Action code bit 15 routes expiry to `irq_o` and bit 14 routes it to `rst_req_o`. Code 2 gives the interrupt only, code 1 the reset request only, code 3 both, and code 0 neither (the expired flag still sets).
- R9: After expiry, the outputs stay high, the count stays at zero, and further writes have no effect until reset.
- R10: If the lock write has the run enable clear, the count never moves and the block never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data; only bits 15:0 matter, and only on the first write |
| rd_data_o | output | 32 | Register read view: config, count, locked, expired |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_req_o | output | 1 | Sticky expiry reset request |

## Verification
The bench builds the block with PRESCALE_DIV set to 4 instead of 16384. This brings the prescaled timeout within a few dozen cycles, so its exact expiry cycle and mid-count readback can be checked against the formula in R7. The no-prescale path keeps its true half-rate step. Small reload counts (1 to 10) keep each expiry, kick-restart and post-expiry write scenario within a short window, with a reset between scenarios because the lock is permanent.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int RELOAD_W = 12;
    localparam int CFG_W    = 16;
    localparam int CNT_LSB  = 16;
    localparam int LOCK_BIT = 28;
    localparam int EXP_BIT  = 29;

    // Field order matches register bits 15:0 (msb first).
    typedef struct packed {
        logic                action_irq;
        logic                action_rst;
        logic                run_en;
        logic                pre_en;
        logic [RELOAD_W-1:0] reload;
    } cfg_t;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
    import wdog_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_cfg_i,
    output cfg_t             cfg_o,
    output logic             locked_o,
    output logic [RELOAD_W-1:0] load_val_o
);
    typedef struct packed {
        cfg_t cfg;
        logic locked;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && !st_q.locked) begin
            st_d.cfg    = cfg_t'(wr_cfg_i);
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cfg_o      = st_q.cfg;
    assign locked_o   = st_q.locked;
    assign load_val_o = st_q.locked ? st_q.cfg.reload : wr_cfg_i[RELOAD_W-1:0];

    a_r3_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.locked |=> ($stable(st_q.cfg) && st_q.locked));
endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int PRESCALE_DIV = 16384
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    input  logic pre_en_i,
    output logic step_o
);
    localparam int PRE_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_DIV - 1);

    typedef struct packed {
        logic             half;
        logic [PRE_W-1:0] pre;
    } st_t;

    st_t  st_d, st_q;
    logic wd_tick;
    logic pre_wrap;

    always_comb begin
        wd_tick  = run_i && !clear_i && st_q.half;
        pre_wrap = (st_q.pre == PRE_LAST);
        st_d     = st_q;
        step_o   = 1'b0;
        if (clear_i) begin
            st_d = '0;
        end else if (run_i) begin
            st_d.half = !st_q.half;
            if (wd_tick) begin
                if (!pre_en_i) begin
                    step_o = 1'b1;
                end else if (pre_wrap) begin
                    st_d.pre = '0;
                    step_o   = 1'b1;
                end else begin
                    st_d.pre = st_q.pre + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    a_r5_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o |=> !step_o);
endmodule

// File: rtl/wdog_count_core.sv
module wdog_count_core
    import wdog_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [RELOAD_W-1:0] load_val_i,
    input  logic                step_i,
    output logic [RELOAD_W-1:0] count_o,
    output logic                expired_o
);
    typedef struct packed {
        logic [RELOAD_W-1:0] count;
        logic                expired;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.count = load_val_i;
        end else if (step_i && !st_q.expired) begin
            if (st_q.count == '0) st_d.expired = 1'b1;
            else                  st_d.count   = st_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o   = st_q.count;
    assign expired_o = st_q.expired;

    a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> (st_q.count == $past(st_q.count) ||
                     st_q.count == $past(st_q.count) - 1'b1));
    a_r7_expire_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.expired) |-> (st_q.count == '0));
    a_r9_frozen_after_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.expired |=> (st_q.expired && $stable(st_q.count)));
endmodule

// File: rtl/wdog_lockcfg.sv
module wdog_lockcfg
    import wdog_pkg::*;
#(
    parameter int PRESCALE_DIV = 16384
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    output logic        irq_o,
    output logic        rst_req_o
);
    cfg_t                cfg;
    logic                locked;
    logic [RELOAD_W-1:0] load_val;
    logic [RELOAD_W-1:0] count;
    logic                expired;
    logic                load;
    logic                step;
    logic                run;
    logic                wr_hi_unused;

    assign wr_hi_unused = ^wr_data_i[31:CFG_W];
    assign load = wr_en_i && !expired;
    assign run  = locked && cfg.run_en && !expired;

    wdog_cfg_reg u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_cfg_i   (wr_data_i[CFG_W-1:0]),
        .cfg_o      (cfg),
        .locked_o   (locked),
        .load_val_o (load_val)
    );

    wdog_tick_gen #(.PRESCALE_DIV(PRESCALE_DIV)) u_tick (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (load),
        .run_i    (run),
        .pre_en_i (cfg.pre_en),
        .step_o   (step)
    );

    wdog_count_core u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_val_i (load_val),
        .step_i     (step),
        .count_o    (count),
        .expired_o  (expired)
    );

    always_comb begin
        rd_data_o                            = '0;
        rd_data_o[CFG_W-1:0]                 = cfg;
        rd_data_o[CNT_LSB +: RELOAD_W]       = count;
        rd_data_o[LOCK_BIT]                  = locked;
        rd_data_o[EXP_BIT]                   = expired;
    end

    assign irq_o     = expired && cfg.action_irq;
    assign rst_req_o = expired && cfg.action_rst;

    a_r9_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> irq_o);
    a_r10_idle_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked && !cfg.run_en && !wr_en_i) |=> ($stable(count) && !expired));
    a_r1_idle_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!locked && !wr_en_i) |=> $stable(count));
endmodule

// File: tb/wdog_lockcfg_tb_top.sv
module wdog_lockcfg_tb_top;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, rst_req;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int exp_q[$];
    logic fire_prev = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_lockcfg #(.PRESCALE_DIV(DIV)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .irq_o(irq), .rst_req_o(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] cfgw(int r, bit pre, bit en, bit [1:0] act);
        return {16'h0, act, en, pre, 12'(r)};
    endfunction

    function automatic logic [31:0] view(logic [31:0] c, int cnt, bit exd);
        return {2'b00, exd, 1'b1, 12'(cnt), c[15:0]};
    endfunction

    // Scoreboard monitor: every rising expiry output pops one expected cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            fire_prev = 1'b0;
        end else begin
            if ((irq || rst_req) && !fire_prev) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R7: unexpected expiry actual=%0d expected=none", cyc);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e != cyc) begin
                        bad++;
                        $display("FAIL R7: expiry cycle actual=%0d expected=%0d", cyc, e);
                    end
                end
            end
            fire_prev = irq || rst_req;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [31:0] d, output int edge_cyc);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        edge_cyc = cyc + 1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: records the expected expiry cycle of an armed watchdog.
    task automatic push_exp(input int w, input int r, input bit pre);
        exp_q.push_back(w + 2 * (pre ? DIV : 1) * (r + 1));
    endtask

    initial begin
        int w, k;
        logic [31:0] c;

        // R1: reset state and idle before the first write
        do_reset();
        @(negedge clk);
        chk("R1 rd after reset", rd_data, 32'h0);
        chk("R1 outputs after reset", {30'h0, irq, rst_req}, 32'h0);
        wait_cyc(cyc + 40);
        chk("R1 idle before config", rd_data, 32'h0);

        // R2, R5, R7, R8, R9: reload 5, no prescale, interrupt action
        c = cfgw(5, 0, 1, 2'd2);
        wr(c, w);
        push_exp(w, 5, 0);
        wait_cyc(w + 1);
        chk("R2 locked readback", rd_data, view(c, 5, 0));
        wait_cyc(w + 5);
        chk("R5 count after 2 steps", rd_data, view(c, 3, 0));
        wait_cyc(w + 14);
        chk("R7 expired view", rd_data, view(c, 0, 1));
        chk("R8 action 2 irq only", {30'h0, irq, rst_req}, 32'h2);
        wr(32'hFFFF_FFFF, k);
        wait_cyc(k + 6);
        chk("R9 write after expiry ignored", rd_data, view(c, 0, 1));
        chk("R9 irq held", {31'h0, irq}, 32'h1);
        chk("R7 scoreboard drained", exp_q.size(), 0);

        // R3, R4: kick restarts from locked reload
        do_reset();
        c = cfgw(10, 0, 1, 2'd2);
        wr(c, w);
        wait_cyc(w + 7);
        wr(32'hFFFF_5003, k);
        push_exp(k, 10, 0);
        wait_cyc(k + 1);
        chk("R4 kick reloads count", rd_data, view(c, 10, 0));
        chk("R3 config unchanged by kick", {16'h0, rd_data[15:0]}, c);
        wait_cyc(k + 24);
        chk("R4 kick expiry drained", exp_q.size(), 0);

        // R6: prescaled, reload 3
        do_reset();
        c = cfgw(3, 1, 1, 2'd2);
        wr(c, w);
        push_exp(w, 3, 1);
        wait_cyc(w + 9);
        chk("R6 count after one prescaled step", rd_data, view(c, 2, 0));
        wait_cyc(w + 2 * DIV * 4 + 2);
        chk("R6 prescaled expiry", {31'h0, irq}, 32'h1);
        chk("R6 scoreboard drained", exp_q.size(), 0);

        // R10: enable clear
        do_reset();
        c = cfgw(2, 0, 0, 2'd2);
        wr(c, w);
        wait_cyc(w + 60);
        chk("R10 disabled holds count", rd_data, view(c, 2, 0));
        chk("R10 no expiry", {30'h0, irq, rst_req}, 32'h0);

        // R8: reset-request action
        do_reset();
        c = cfgw(1, 0, 1, 2'd1);
        wr(c, w);
        push_exp(w, 1, 0);
        wait_cyc(w + 6);
        chk("R8 action 1 reset request only", {30'h0, irq, rst_req}, 32'h1);

        // R8: both outputs
        do_reset();
        c = cfgw(1, 0, 1, 2'd3);
        wr(c, w);
        push_exp(w, 1, 0);
        wait_cyc(w + 6);
        chk("R8 action 3 both outputs", {30'h0, irq, rst_req}, 32'h3);

        // R8: action 0 flags only
        do_reset();
        c = cfgw(1, 0, 1, 2'd0);
        wr(c, w);
        wait_cyc(w + 10);
        chk("R8 action 0 no outputs", {30'h0, irq, rst_req}, 32'h0);
        chk("R8 action 0 expired flag", rd_data, view(c, 0, 1));
        chk("R7 all expiries seen", exp_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule